// File: doc/BRIEF.md
# Single-Vector Message Interrupt Capability

This block holds the message-signalled interrupt capability of a PCI function that raises one interrupt vector. Software reaches it through a configuration port. The port is addressed in dwords relative to the capability base, takes byte enables on writes and returns read data combinationally. Through this port software sets up the message address, the message data, the enable and the mask bit. Writes pass byte by byte through a filter, so the identifier, the link pointer and the read-only control flags keep their values.

On the device side, a one-cycle interrupt request either starts a memory-write message or is latched as pending. The message leaves as an address/data pair with a valid/ready handshake. When a vector is masked, its request is held as pending and is not dropped. As soon as the function is enabled, unmasked and pending, the held message goes out. Requests that arrive while a message waits for ready are merged into the pending bit and cause one further message after the handshake.

A two-state machine sends the messages. `SND_IDLE` waits for a launch condition: enable set, mask clear, and either a request or a pending bit. The transition *launch* leads to `SND_WAIT`. `SND_WAIT` holds the captured message until ready, and the transition *accept* leads back to `SND_IDLE`. Launch and accept are the only transitions.

Top module: `msi_vector_cap`

## Requirements
- R1: After reset, enable, multiple-message field, mask, pending, address and data are all zero and `msg_valid` is low. Dword 0 reads `{8'h01, ctrl_lo, NEXT_PTR, 8'h05}`, where ctrl_lo is 8'h80 when ADDR64 is set and 8'h00 when it is clear.
- R2: Bytes 0 (identifier 8'h05) and 1 (link pointer NEXT_PTR) of dword 0 ignore every write.
- R3: In byte 2 of dword 0, only bit 16 (enable) and bits 22:20 (multiple-message field) accept writes. Bits 19:17 always read 0, and bit 23 reads ADDR64.
- R4: Byte 3 of dword 0 always reads 8'h01, which reports per-vector masking capable, and it ignores writes.
- R5: The layout with ADDR64=1 is: dword 1 address low, dword 2 address high, dword 3 data in bits 15:0 (bits 31:16 read 0), dword 4 mask in bit 0, dword 5 pending in bit 0 (read-only). With ADDR64=0, data, mask and pending move to dwords 2, 3 and 4 and the address high half is zero. Each byte enable gates its own byte. Other bits and dwords read 0.
- R6: A request with enable set and mask clear in `SND_IDLE` raises `msg_valid` after the next clock edge. The message carries the address `{high, low}` and the data zero-extended to 32 bits.
- R7: A request with enable set and mask set sets the pending bit and sends nothing.
- R8: When enable is set, the mask is clear and the pending bit is set, a message launches on the next edge and the pending bit clears. Clearing a set mask while pending is therefore followed by a message on the edge after the write.
- R9: A request while enable is clear changes nothing: no message, no pending bit.
- R10: `msg_valid` stays high with `msg_addr` and `msg_data` unchanged until an edge with `msg_ready` high. Rewriting registers during the wait does not alter the message in flight.
- R11: A request that arrives in `SND_WAIT` with enable set sets the pending bit, so a second message follows the handshake.
- R12: The multiple-message field reads back as written and never changes the emitted data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_dw | input | 3 | Dword index relative to capability base |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_dw` (combinational) |
| irq | input | 1 | One-cycle interrupt request |
| msg_valid | output | 1 | Message write request valid |
| msg_ready | input | 1 | Message accepted when high with valid |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data, zero-extended |

## Verification
Register writes take effect on the clock edge that samples `cfg_wr`, and reads are combinational. The bench therefore reads back on the falling edge that follows the write. An unmasked request raises `msg_valid` one edge after it is sampled, so the bench checks valid on the falling edge right after the request pulse. A mask-clearing write produces valid one edge after the write lands; the bench polls for at most four falling edges and flags anything later. After an accepting edge, valid must be low at the next falling edge, even when a merged pending message will relaunch one edge later.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;

    typedef enum logic [0:0] {
        SND_IDLE = 1'b0,
        SND_WAIT = 1'b1
    } snd_state_e;

    localparam logic [7:0] MSI_CAP_ID   = 8'h05;
    localparam logic [7:0] CTRL_HI_FLAGS = 8'h01;

    function automatic logic [2:0] data_dword(input bit wide);
        return wide ? 3'd3 : 3'd2;
    endfunction

endpackage

// File: rtl/msi_cfg_regs.sv
module msi_cfg_regs
    import msi_cap_pkg::*;
#(
    parameter bit         ADDR64   = 1'b1,
    parameter logic [7:0] NEXT_PTR = 8'h00
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic [2:0]  dw,
    input  logic [3:0]  be,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    input  logic        pend,
    output logic        en,
    output logic        mask,
    output logic [63:0] addr,
    output logic [15:0] data
);

    localparam logic [2:0] DW_CTRL = 3'd0;
    localparam logic [2:0] DW_ALO  = 3'd1;
    localparam logic [2:0] DW_AHI  = 3'd2;
    localparam logic [2:0] DW_DATA = data_dword(ADDR64);
    localparam logic [2:0] DW_MASK = DW_DATA + 3'd1;
    localparam logic [2:0] DW_PEND = DW_DATA + 3'd2;

    logic        en_q;
    logic [2:0]  mme_q;
    logic        mask_q;
    logic [31:0] alo_q;
    logic [31:0] ahi_q;
    logic [15:0] data_q;

    // Byte-filtered writes: only writable fields of addressed dwords change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            mme_q  <= 3'b000;
            mask_q <= 1'b0;
            alo_q  <= '0;
            data_q <= '0;
        end else if (wr) begin
            if (dw == DW_CTRL && be[2]) begin
                en_q  <= wdata[16];
                mme_q <= wdata[22:20];
            end
            if (dw == DW_ALO) begin
                for (int b = 0; b < 4; b++) begin
                    if (be[b]) alo_q[8*b +: 8] <= wdata[8*b +: 8];
                end
            end
            if (dw == DW_DATA) begin
                for (int b = 0; b < 2; b++) begin
                    if (be[b]) data_q[8*b +: 8] <= wdata[8*b +: 8];
                end
            end
            if (dw == DW_MASK && be[0]) begin
                mask_q <= wdata[0];
            end
        end
    end

    generate
        if (ADDR64) begin : g_addr_hi
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ahi_q <= '0;
                end else if (wr && dw == DW_AHI) begin
                    for (int b = 0; b < 4; b++) begin
                        if (be[b]) ahi_q[8*b +: 8] <= wdata[8*b +: 8];
                    end
                end
            end
        end else begin : g_addr_lo_only
            assign ahi_q = '0;
        end
    endgenerate

    always_comb begin
        rdata = '0;
        if (dw == DW_CTRL) begin
            rdata = {CTRL_HI_FLAGS, 1'(ADDR64), mme_q, 3'b000, en_q, NEXT_PTR, MSI_CAP_ID};
        end else if (dw == DW_ALO) begin
            rdata = alo_q;
        end else if (ADDR64 && dw == DW_AHI) begin
            rdata = ahi_q;
        end else if (dw == DW_DATA) begin
            rdata = {16'h0000, data_q};
        end else if (dw == DW_MASK) begin
            rdata = {31'b0, mask_q};
        end else if (dw == DW_PEND) begin
            rdata = {31'b0, pend};
        end
    end

    assign en   = en_q;
    assign mask = mask_q;
    assign addr = {ahi_q, alo_q};
    assign data = data_q;

endmodule

// File: rtl/msi_send_fsm.sv
module msi_send_fsm
    import msi_cap_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        irq,
    input  logic        en,
    input  logic        mask,
    input  logic [63:0] addr,
    input  logic [15:0] data,
    input  logic        msg_ready,
    output logic        msg_valid,
    output logic [63:0] msg_addr,
    output logic [31:0] msg_data,
    output logic        pend
);

    snd_state_e  state_q, state_d;
    logic        pend_q;
    logic [63:0] addr_q;
    logic [31:0] data_q;
    logic        launch;

    assign launch = (state_q == SND_IDLE) && en && !mask && (irq || pend_q);

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SND_IDLE: if (launch)    state_d = SND_WAIT;
            SND_WAIT: if (msg_ready) state_d = SND_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SND_IDLE;
        else        state_q <= state_d;
    end

    // Output and pending registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            if (launch) begin
                pend_q <= 1'b0;
                addr_q <= addr;
                data_q <= {16'h0000, data};
            end else if (irq && en && (mask || state_q == SND_WAIT)) begin
                pend_q <= 1'b1;
            end
        end
    end

    assign msg_valid = (state_q == SND_WAIT);
    assign msg_addr  = addr_q;
    assign msg_data  = data_q;
    assign pend      = pend_q;

endmodule

// File: rtl/msi_vector_cap.sv
module msi_vector_cap
    import msi_cap_pkg::*;
#(
    parameter bit         ADDR64   = 1'b1,
    parameter logic [7:0] NEXT_PTR = 8'h00
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic [2:0]  cfg_dw,
    input  logic [3:0]  cfg_be,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        irq,
    output logic        msg_valid,
    input  logic        msg_ready,
    output logic [63:0] msg_addr,
    output logic [31:0] msg_data
);

    logic        en_w;
    logic        mask_w;
    logic        pend_w;
    logic [63:0] addr_w;
    logic [15:0] data_w;

    msi_cfg_regs #(
        .ADDR64   (ADDR64),
        .NEXT_PTR (NEXT_PTR)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (cfg_wr),
        .dw    (cfg_dw),
        .be    (cfg_be),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .pend  (pend_w),
        .en    (en_w),
        .mask  (mask_w),
        .addr  (addr_w),
        .data  (data_w)
    );

    msi_send_fsm u_send (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq       (irq),
        .en        (en_w),
        .mask      (mask_w),
        .addr      (addr_w),
        .data      (data_w),
        .msg_ready (msg_ready),
        .msg_valid (msg_valid),
        .msg_addr  (msg_addr),
        .msg_data  (msg_data),
        .pend      (pend_w)
    );

endmodule

// File: rtl/msi_vector_cap_chk.sv
module msi_vector_cap_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        irq,
    input logic        en,
    input logic        mask,
    input logic        pend,
    input logic        msg_valid,
    input logic        msg_ready,
    input logic [63:0] msg_addr,
    input logic [31:0] msg_data
);

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

    assert_zext_R6: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_data[31:16] == 16'h0000));

    assert_launch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && en && !mask && !msg_valid) |=> msg_valid);

    assert_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> $past(en && !mask));

    assert_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && en && mask) |=> pend);

    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> !pend);

endmodule

bind msi_vector_cap msi_vector_cap_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq       (irq),
    .en        (en_w),
    .mask      (mask_w),
    .pend      (pend_w),
    .msg_valid (msg_valid),
    .msg_ready (msg_ready),
    .msg_addr  (msg_addr),
    .msg_data  (msg_data)
);

// File: tb/msi_vector_cap_test.sv
module msi_vector_cap_test;

    localparam logic [7:0] NEXT = 8'h60;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wr;
    logic [2:0]  cfg_dw;
    logic [3:0]  cfg_be;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic        irq;
    logic        msg_valid;
    logic        msg_ready;
    logic [63:0] msg_addr;
    logic [31:0] msg_data;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    msi_vector_cap #(.ADDR64(1'b1), .NEXT_PTR(NEXT)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dw(cfg_dw), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq(irq), .msg_valid(msg_valid),
        .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
    );

    function automatic logic [31:0] exp_ctrl(input logic e, input logic [2:0] mme);
        return {8'h01, 1'b1, mme, 3'b000, e, NEXT, 8'h05};
    endfunction

    function automatic logic exp_sends(input logic e, input logic m);
        return e && !m;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] dw, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_dw = dw; cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] dw, output logic [31:0] d);
        cfg_dw = dw;
        #1;
        d = cfg_rdata;
    endtask

    task automatic pulse_irq();
        @(negedge clk);
        irq = 1'b1;
        @(negedge clk);
        irq = 1'b0;
    endtask

    task automatic take(input string tag, input logic [63:0] a, input logic [31:0] d);
        int n = 0;
        while (!msg_valid && n < 4) begin
            @(negedge clk);
            n++;
        end
        chk({tag, " valid"}, 64'(msg_valid), 64'd1);
        chk({tag, " addr"}, msg_addr, a);
        chk({tag, " data"}, 64'(msg_data), 64'(d));
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
        chk({tag, " valid low after accept"}, 64'(msg_valid), 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [63:0] a;
        logic [15:0] d;
        void'($urandom(32'h5EED1234));
        rst_n = 1'b0; cfg_wr = 1'b0; cfg_dw = '0; cfg_be = '0; cfg_wdata = '0;
        irq = 1'b0; msg_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(3'd0, r); chk("R1 dword0", 64'(r), 64'(exp_ctrl(1'b0, 3'd0)));
        rd(3'd4, r); chk("R1 mask", 64'(r), 64'd0);
        rd(3'd5, r); chk("R1 pending", 64'(r), 64'd0);
        chk("R1 valid", 64'(msg_valid), 64'd0);

        // R2 identifier and link pointer ignore writes
        wr(3'd0, 4'b0011, 32'hFFFF_FFFF);
        rd(3'd0, r); chk("R2 id/next", 64'(r), 64'(exp_ctrl(1'b0, 3'd0)));

        // R3 / R12 low control byte filtering and mme readback
        wr(3'd0, 4'b0100, 32'h00FF_0000);
        rd(3'd0, r); chk("R3 R12 ctrl low", 64'(r), 64'(exp_ctrl(1'b1, 3'd7)));
        wr(3'd0, 4'b0100, 32'h0000_0000);
        rd(3'd0, r); chk("R3 ctrl cleared", 64'(r), 64'(exp_ctrl(1'b0, 3'd0)));

        // R4 high control byte read-only
        wr(3'd0, 4'b1000, 32'hFF00_0000);
        rd(3'd0, r); chk("R4 ctrl high", 64'(r), 64'(exp_ctrl(1'b0, 3'd0)));

        // R5 layout and byte enables
        wr(3'd1, 4'b0101, 32'hAABB_CCDD);
        rd(3'd1, r); chk("R5 addr lo bytes", 64'(r), 64'h00BB_00DD);
        wr(3'd3, 4'b1111, 32'hFFFF_1234);
        rd(3'd3, r); chk("R5 data upper zero", 64'(r), 64'h0000_1234);
        wr(3'd5, 4'b1111, 32'hFFFF_FFFF);
        rd(3'd5, r); chk("R5 pending read-only", 64'(r), 64'd0);
        wr(3'd4, 4'b1111, 32'hFFFF_FFFF);
        rd(3'd4, r); chk("R5 mask bit0 only", 64'(r), 64'd1);
        wr(3'd4, 4'b1111, 32'h0);
        rd(3'd6, r); chk("R5 unused dword", 64'(r), 64'd0);

        // R9 request while disabled
        pulse_irq();
        chk("R9 no message", 64'(msg_valid), 64'd0);
        rd(3'd5, r); chk("R9 no pending", 64'(r), 64'd0);

        // R6 R7 R8 R9 randomized
        for (int i = 0; i < 40; i++) begin
            logic e, m;
            a = {$urandom, $urandom};
            d = 16'($urandom);
            e = ($urandom % 4) != 0;
            m = 1'($urandom);
            wr(3'd1, 4'hF, a[31:0]);
            wr(3'd2, 4'hF, a[63:32]);
            wr(3'd3, 4'hF, {16'h0, d});
            wr(3'd4, 4'hF, {31'b0, m});
            wr(3'd0, 4'b0100, {15'b0, e, 16'b0});
            pulse_irq();
            chk("R6 R7 R9 valid after request", 64'(msg_valid), 64'(exp_sends(e, m)));
            rd(3'd5, r); chk("R7 R9 pending", 64'(r), 64'(e && m));
            if (exp_sends(e, m)) take("R6 message", a, {16'h0, d});
            if (e && m) begin
                wr(3'd4, 4'h1, 32'h0);
                take("R8 replay", a, {16'h0, d});
                rd(3'd5, r); chk("R8 pending cleared", 64'(r), 64'd0);
            end
        end

        // R10 hold and stability while stalled
        wr(3'd0, 4'b0100, 32'h0001_0000);
        wr(3'd4, 4'h1, 32'h0);
        wr(3'd1, 4'hF, 32'h1111_2220);
        wr(3'd2, 4'hF, 32'h0000_0003);
        wr(3'd3, 4'hF, 32'h0000_4321);
        pulse_irq();
        wr(3'd1, 4'hF, 32'h9999_8888);
        wr(3'd3, 4'hF, 32'h0000_0BAD);
        chk("R10 valid held", 64'(msg_valid), 64'd1);
        chk("R10 addr stable", msg_addr, 64'h0000_0003_1111_2220);
        take("R10 message", 64'h0000_0003_1111_2220, 32'h0000_4321);

        // R11 request during wait merges into one extra message
        pulse_irq();
        pulse_irq();
        rd(3'd5, r); chk("R11 pending set in wait", 64'(r), 64'd1);
        take("R11 first", 64'h0000_0003_9999_8888, 32'h0000_0BAD);
        take("R11 second", 64'h0000_0003_9999_8888, 32'h0000_0BAD);
        repeat (3) @(negedge clk);
        chk("R11 no third", 64'(msg_valid), 64'd0);

        // R12 multiple-message field does not alter data
        wr(3'd0, 4'b0100, 32'h0071_0000);
        pulse_irq();
        take("R12 data unchanged", 64'h0000_0003_9999_8888, 32'h0000_0BAD);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule